// File: doc/BRIEF.md
# Interrupt Event Router with End-of-Interrupt Re-arm

This block takes a 128-bit vector of system events and routes any of them to twelve CPU interrupt lines and to one shared exception line. The interrupt lines are numbered 4 to 15. Events arrive from logic that runs on a slower clock, so each one is first brought into the CPU clock domain through a two-flop synchronizer. Event 0 is reserved and is treated as never asserted.

Each interrupt line has a select register that names one event. The line gives a one-cycle pulse each time that event rises. The exception line is the OR of every event enabled in a 128-bit exception mask. A sticky cause vector records which masked events were seen, and software clears it one bit at a time with write-one-to-clear.

A few sources drive level-sensitive interrupts and are grouped into sources with one or four lines. After such a line has pulsed once, it stays quiet until software writes an end-of-interrupt (EOI) record naming the source and the line. That write re-arms the line, and if the level is still high the line pulses again straight away. Every setting goes through one write port with address, data and write enable.

Top module: `irq_evt_router`

## Requirements
- R1: After reset, all twelve selects point to reserved event 0, the exception mask is zero, and all level lines are armed. While the mask stays zero, no input pattern produces an interrupt pulse, an exception or a cause bit, even with evtIn[0] high.
- R2: A write to address i (0 to 11) loads wrData[6:0] into the select of interrupt line 4+i, and the upper data bits are ignored. A write to addresses 0x0C to 0x0F changes no select.
- R3: When the selected event rises, irqOut[i] (line 4+i) goes high after the third rising clock edge following the input change and stays high for exactly one cycle. No further pulse follows while the input stays high or when it falls.
- R4: For an edge event, every rise gives a new pulse. Outputs that select the same event pulse in the same cycle.
- R5: Mask word w is written at address 0x10+w, and bit b of that word enables event 32w+b. excOut is high exactly when a masked event was high two edges earlier, so its latency matches R3.
- R6: The cause bit of a masked event is set together with excOut and stays set after the event drops. A write at address 0x18+w clears the cause bits of word w whose data bits are 1 and leaves the others set.
- R7: A level line pulses once on its rise. It then gives no further pulse, whether its input stays high or falls and rises again, until a matching EOI arrives.
- R8: A write to address 0x20 is an EOI, with the source ID in wrData[15:8] and the line value in wrData[7:0]. A matching EOI re-arms that line. If its input is still high, the line pulses in the cycle after the write edge; if the input is low, the next rise pulses as usual. An EOI with an unknown source or a value at or above the source's line count has no effect.
- R9: The level sources are fixed as follows. Source 0 is event 30 and source 2 is event 50, each with one line that takes EOI value 0. Source 1 has four lines, events 40 to 43, which take values 0 to 3. Source 3 is event 60, with one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 128 | System event inputs from the slower domain |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 8 | Register write address |
| wrData | input | 32 | Register write data |
| irqOut | output | 12 | Interrupt pulses; bit i drives CPU interrupt 4+i |
| excOut | output | 1 | Exception line (OR of masked events) |
| excCause | output | 128 | Sticky record of masked events seen |

## Verification
An input change reaches irqOut, excOut and excCause at the third rising edge after the change: two synchronizer flops plus the output register. A register write takes effect at its own write edge, and a re-arming EOI on a line whose input is still high pulses one edge after the write. The bench drives inputs and samples outputs 1 ns after each rising edge. It keeps a shift history of the input vector and predicts each edge's outputs from the entry two edges back, compared against the entry three edges back. Directed checks count those edges explicitly around each write.

// File: rtl/irq_rtr_pkg.sv
`timescale 1ns/1ps
package irq_rtr_pkg;
  localparam int EVT_CNT     = 128;
  localparam int EVT_W       = $clog2(EVT_CNT);
  localparam int OUT_CNT     = 12;
  localparam int OUT_BASE    = 4;
  localparam int OUT_W       = $clog2(OUT_CNT);
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int WORD_CNT    = EVT_CNT / DATA_W;
  localparam int WORD_W      = $clog2(WORD_CNT);
  localparam int RSVD_EVT    = 0;
  localparam int SYNC_STAGES = 2;
  localparam int ID_W        = 8;
  localparam int LVL_SRC_CNT = 4;

  localparam logic [ADDR_W-1:0] MASK_BASE_ADDR  = 8'h10;
  localparam logic [ADDR_W-1:0] CAUSE_BASE_ADDR = 8'h18;
  localparam logic [ADDR_W-1:0] EOI_ADDR        = 8'h20;

  // first event of each level source
  function automatic int lvlBase(int s);
    case (s)
      0:       return 30;
      1:       return 40;
      2:       return 50;
      default: return 60;
    endcase
  endfunction

  // number of lines of each level source
  function automatic int lvlLines(int s);
    case (s)
      1:       return 4;
      default: return 1;
    endcase
  endfunction

  // index of the first arming slot owned by source s
  function automatic int lvlFirstSlot(int s);
    int acc;
    acc = 0;
    for (int k = 0; k < s; k++) acc += lvlLines(k);
    return acc;
  endfunction

  localparam int LVL_SLOTS = lvlFirstSlot(LVL_SRC_CNT);

  function automatic int slotSrc(int j);
    for (int s = 0; s < LVL_SRC_CNT; s++)
      if (j < lvlFirstSlot(s + 1)) return s;
    return 0;
  endfunction

  // arming slot of an event, or -1 for an edge event
  function automatic int slotOfEvt(int e);
    for (int s = 0; s < LVL_SRC_CNT; s++)
      if (e >= lvlBase(s) && e < lvlBase(s) + lvlLines(s))
        return lvlFirstSlot(s) + e - lvlBase(s);
    return -1;
  endfunction

  typedef struct packed {
    logic              selWr;
    logic [OUT_W-1:0]  selIdx;
    logic              maskWr;
    logic              causeClr;
    logic [WORD_W-1:0] word;
    logic              eoiWr;
    logic [ID_W-1:0]   eoiSrc;
    logic [ID_W-1:0]   eoiVal;
    logic [DATA_W-1:0] data;
  } ctrl_strb_t;
endpackage

// File: rtl/irq_rtr_sync.sv
`timescale 1ns/1ps
module irq_rtr_sync
  import irq_rtr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [EVT_CNT-1:0] evtIn,
  output logic [EVT_CNT-1:0] evtSync
);
  localparam logic [EVT_CNT-1:0] RSVD_MASK = EVT_CNT'(1) << RSVD_EVT;

  logic [EVT_CNT-1:0] stage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= evtIn & ~RSVD_MASK;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign evtSync = stage[SYNC_STAGES-1];
endmodule

// File: rtl/irq_rtr_ctrl.sv
`timescale 1ns/1ps
module irq_rtr_ctrl
  import irq_rtr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrl_strb_t        strb
);
  localparam logic [ADDR_W-1:0] SEL_LIMIT = ADDR_W'(OUT_CNT);

  always_comb begin
    strb        = '0;
    strb.data   = wrData;
    strb.selIdx = wrAddr[OUT_W-1:0];
    strb.word   = wrAddr[WORD_W-1:0];
    strb.eoiVal = wrData[ID_W-1:0];
    strb.eoiSrc = wrData[2*ID_W-1:ID_W];
    if (wrEn) begin
      if (wrAddr < SEL_LIMIT)
        strb.selWr = 1'b1;
      else if (wrAddr[ADDR_W-1:WORD_W] == MASK_BASE_ADDR[ADDR_W-1:WORD_W])
        strb.maskWr = 1'b1;
      else if (wrAddr[ADDR_W-1:WORD_W] == CAUSE_BASE_ADDR[ADDR_W-1:WORD_W])
        strb.causeClr = 1'b1;
      else if (wrAddr == EOI_ADDR)
        strb.eoiWr = 1'b1;
    end
  end

  // R2: a single write never reaches two register groups
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selWr, strb.maskWr, strb.causeClr, strb.eoiWr}));
endmodule

// File: rtl/irq_rtr_datapath.sv
`timescale 1ns/1ps
module irq_rtr_datapath
  import irq_rtr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [EVT_CNT-1:0] evtSync,
  input  ctrl_strb_t         strb,
  output logic [OUT_CNT-1:0] irqOut,
  output logic               excOut,
  output logic [EVT_CNT-1:0] excCause
);
  logic [EVT_W-1:0]     selReg [OUT_CNT];
  logic [EVT_CNT-1:0]   excMask;
  logic [EVT_CNT-1:0]   gated, gatedPrev, riseVec, clrVec;
  logic [LVL_SLOTS-1:0] armed, armNext, eoiHit;

  // level arming slots, one per line of each level source
  for (genvar j = 0; j < LVL_SLOTS; j++) begin : g_slot
    localparam int SRC  = slotSrc(j);
    localparam int LINE = j - lvlFirstSlot(SRC);
    localparam int EVT  = lvlBase(SRC) + LINE;

    assign eoiHit[j]  = strb.eoiWr && (strb.eoiSrc == ID_W'(SRC))
                        && (strb.eoiVal == ID_W'(LINE));
    // EOI wins over the consuming rise in the same cycle
    assign armNext[j] = eoiHit[j] ? 1'b1 : (riseVec[EVT] ? 1'b0 : armed[j]);

    a_r8_eoi_rearms: assert property (@(posedge clk) disable iff (!rstN)
      eoiHit[j] |=> armed[j]);
    a_r7_stays_disarmed: assert property (@(posedge clk) disable iff (!rstN)
      (!armed[j] && !eoiHit[j]) |=> !armed[j]);
  end

  // level events pass only while armed
  for (genvar e = 0; e < EVT_CNT; e++) begin : g_evt
    localparam int SLOT = slotOfEvt(e);
    if (SLOT >= 0) begin : g_lvl
      assign gated[e] = evtSync[e] & armed[SLOT];
    end else begin : g_edge
      assign gated[e] = evtSync[e];
    end
  end

  assign riseVec = gated & ~gatedPrev;

  always_comb begin
    clrVec = '0;
    for (int w = 0; w < WORD_CNT; w++)
      if (strb.causeClr && strb.word == WORD_W'(w))
        clrVec[w*DATA_W +: DATA_W] = strb.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < OUT_CNT; i++) selReg[i] <= EVT_W'(RSVD_EVT);
      excMask   <= '0;
      armed     <= '1;
      gatedPrev <= '0;
      irqOut    <= '0;
      excOut    <= 1'b0;
      excCause  <= '0;
    end else begin
      if (strb.selWr) selReg[strb.selIdx] <= strb.data[EVT_W-1:0];
      for (int w = 0; w < WORD_CNT; w++)
        if (strb.maskWr && strb.word == WORD_W'(w))
          excMask[w*DATA_W +: DATA_W] <= strb.data;
      armed     <= armNext;
      gatedPrev <= gated;
      for (int i = 0; i < OUT_CNT; i++) irqOut[i] <= riseVec[selReg[i]];
      excOut    <= |(evtSync & excMask);
      excCause  <= (excCause & ~clrVec) | (evtSync & excMask);
    end
  end

  // R3: a pulse lasts one cycle unless a select was rewritten under it
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut != '0) && !$past(strb.selWr)) |=> ((irqOut & $past(irqOut)) == '0));
  // R5: the exception line never rises without a recorded cause
  a_r5_exc_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    excOut |-> (excCause != '0));
  // R6: cause bits only drop through a clear write
  a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.causeClr |=> (($past(excCause) & ~excCause) == '0));
endmodule

// File: rtl/irq_evt_router.sv
`timescale 1ns/1ps
module irq_evt_router
  import irq_rtr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [EVT_CNT-1:0] evtIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [OUT_CNT-1:0] irqOut,
  output logic               excOut,
  output logic [EVT_CNT-1:0] excCause
);
  logic [EVT_CNT-1:0] evtSync;
  ctrl_strb_t         strb;

  irq_rtr_sync u_sync (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .evtSync(evtSync)
  );

  irq_rtr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strb(strb)
  );

  irq_rtr_datapath u_dp (
    .clk(clk), .rstN(rstN), .evtSync(evtSync), .strb(strb),
    .irqOut(irqOut), .excOut(excOut), .excCause(excCause)
  );
endmodule

// File: tb/irq_evt_router_test.sv
`timescale 1ns/1ps
module irq_evt_router_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [7:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [127:0] evtIn = '0;
  logic [11:0]  irqOut;
  logic         excOut;
  logic [127:0] excCause;

  irq_evt_router uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .irqOut(irqOut), .excOut(excOut), .excCause(excCause)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [127:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;
  int selM [12];
  logic [127:0] maskM = '0;
  logic [127:0] lvlMask;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // history: h0 = input at the latest edge, h2 = two edges before
  task automatic step();
    h3 = h2; h2 = h1; h1 = h0; h0 = evtIn;
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  function automatic logic [11:0] expIrq();
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = h2[selM[i]] & ~h3[selM[i]];
    return r;
  endfunction

  function automatic logic expExc();
    return |(h2 & maskM);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] acc;
    logic [127:0] allowed;
    int unsigned seed;
    lvlMask = '0;
    lvlMask[30] = 1'b1; lvlMask[50] = 1'b1; lvlMask[60] = 1'b1;
    lvlMask[43:40] = 4'hF;
    for (int i = 0; i < 12; i++) selM[i] = 0;
    seed = $urandom(32'd2024);

    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1", "irq after reset", irqOut, 0);
    chk("R1", "exc after reset", excOut, 0);
    chk("R1", "cause after reset", excCause, 0);
    evtIn = ~lvlMask;
    acc = '0;
    repeat (5) begin step(); acc |= irqOut; end
    chk("R1", "irq with all edge events high", acc, 0);
    chk("R1", "exc with zero mask", excOut, 0);
    chk("R1", "cause with zero mask", excCause, 0);
    evtIn = '0;
    repeat (4) step();

    // R3 latency and single-cycle pulse
    regWrite(8'h00, 32'd5);
    evtIn[5] = 1'b1;
    step(); chk("R3", "edge1", irqOut[0], 0);
    step(); chk("R3", "edge2", irqOut[0], 0);
    step(); chk("R3", "edge3 pulse", irqOut[0], 1);
    step(); chk("R3", "edge4 held", irqOut[0], 0);
    evtIn[5] = 1'b0;
    acc = '0;
    repeat (3) begin step(); acc |= irqOut; end
    chk("R3", "no pulse on fall", acc, 0);

    // R2 select writes, ignored address, ignored upper bits
    regWrite(8'h0B, 32'd9);
    regWrite(8'h0C, 32'd10);
    regWrite(8'h01, 32'h0000_008C);
    evtIn[10] = 1'b1;
    acc = '0;
    repeat (4) begin step(); acc |= irqOut; end
    chk("R2", "address 0x0C ignored", acc, 0);
    evtIn[9] = 1'b1; evtIn[12] = 1'b1;
    step(); step(); step();
    chk("R2", "line15->9 and line5->12", irqOut, 12'h802);
    evtIn = '0;
    repeat (4) step();

    // R4 fan-out and repeat rises
    regWrite(8'h02, 32'd20);
    regWrite(8'h03, 32'd20);
    evtIn[20] = 1'b1;
    step(); step(); step();
    chk("R4", "shared event pulse", irqOut, 12'h00C);
    step(); chk("R4", "shared pulse ends", irqOut, 0);
    evtIn[20] = 1'b0;
    step(); step();
    evtIn[20] = 1'b1;
    step(); step(); step();
    chk("R4", "second rise pulses", irqOut, 12'h00C);
    evtIn[20] = 1'b0;
    repeat (3) step();

    // R5 exception mask, R6 sticky cause
    regWrite(8'h11, 32'h0000_0008);
    evtIn[35] = 1'b1; evtIn[36] = 1'b1;
    step(); step();
    chk("R5", "exc before latency", excOut, 0);
    step();
    chk("R5", "exc raised", excOut, 1);
    chk("R6", "cause only masked", excCause, 128'h1 << 35);
    evtIn[35] = 1'b0; evtIn[36] = 1'b0;
    step(); step(); step();
    chk("R5", "exc drops", excOut, 0);
    chk("R6", "cause sticky", excCause, 128'h1 << 35);
    regWrite(8'h19, 32'h0000_0010);
    chk("R6", "other bit clear keeps", excCause, 128'h1 << 35);
    regWrite(8'h19, 32'h0000_0008);
    chk("R6", "w1c clears", excCause, 0);

    // R7 level line, R9 source 0 at event 30
    regWrite(8'h04, 32'd30);
    evtIn[30] = 1'b1;
    step(); step(); step();
    chk("R7", "level first pulse", irqOut[4], 1);
    step(); chk("R7", "level pulse ends", irqOut[4], 0);
    evtIn[30] = 1'b0;
    repeat (3) step();
    evtIn[30] = 1'b1;
    acc = '0;
    repeat (5) begin step(); acc |= irqOut; end
    chk("R7", "re-rise without EOI", acc, 0);

    // R8 EOI re-arm while high
    regWrite(8'h20, 32'h0000_0000);
    chk("R8", "write edge", irqOut[4], 0);
    step(); chk("R8", "pulse after EOI", irqOut[4], 1);
    step(); chk("R8", "one pulse only", irqOut[4], 0);
    regWrite(8'h20, 32'h0000_0001);
    regWrite(8'h20, 32'h0000_0500);
    acc = '0;
    repeat (3) begin step(); acc |= irqOut; end
    chk("R8", "bad value and bad source ignored", acc, 0);

    // R9 four-line source 1, line 2 is event 42
    regWrite(8'h05, 32'd42);
    evtIn[42] = 1'b1;
    step(); step(); step();
    chk("R9", "event 42 first pulse", irqOut[5], 1);
    regWrite(8'h20, 32'h0000_0101);
    acc = irqOut;
    repeat (2) begin step(); acc |= irqOut; end
    chk("R9", "EOI on line 1 leaves line 2", acc, 0);
    regWrite(8'h20, 32'h0000_0102);
    step();
    chk("R9", "EOI on line 2 re-arms", irqOut[5], 1);

    // R8 re-arm while low, next rise pulses
    evtIn[30] = 1'b0;
    repeat (3) step();
    regWrite(8'h20, 32'h0000_0000);
    acc = '0;
    repeat (3) begin step(); acc |= irqOut; end
    chk("R8", "EOI while low is silent", acc, 0);
    evtIn[30] = 1'b1;
    step(); step(); step();
    chk("R8", "rise after low EOI", irqOut[4], 1);
    evtIn = '0;
    repeat (4) step();

    // R4 / R5 constrained random on edge events
    allowed = ~lvlMask & ~128'h1;
    for (int i = 0; i < 12; i++) begin
      int e;
      e = 1 + int'($urandom % 127);
      while (lvlMask[e]) e = 1 + int'($urandom % 127);
      selM[i] = e;
      regWrite(8'(i), 32'(e));
    end
    for (int w = 0; w < 4; w++) begin
      maskM[w*32 +: 32] = $urandom & allowed[w*32 +: 32];
      regWrite(8'h10 + 8'(w), maskM[w*32 +: 32]);
    end
    repeat (4) step();
    for (int c = 0; c < 400; c++) begin
      logic [127:0] tog;
      tog = {$urandom, $urandom, $urandom, $urandom}
          & {$urandom, $urandom, $urandom, $urandom} & allowed;
      evtIn ^= tog;
      step();
      chk("R4", "random irq", irqOut, expIrq());
      chk("R5", "random exc", excOut, expExc());
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule